// File: doc/BRIEF.md
# E1 Timeslot Multiplexer from Serial TDM Streams

This block builds an E1 line bitstream from two 2048 kbit/s serial TDM inputs that share one bit clock and one 8 kHz frame pulse. Each frame holds 32 channels of 8 bits, 256 bit cells in all. The data input supplies the voice traffic. The control input supplies timeslot 0 and, by default, timeslot 16. The choice is made per timeslot, one bit cell at a time, so the block needs no frame store.

A mode flag sits inside the control stream itself. When it is set, timeslot 16 carries data channel 16 unchanged, which gives common channel signalling. When it is clear, timeslot 16 comes from the control stream. Input bits are sampled on the falling clock edge. The chosen bit is launched on the next rising edge, so the line output trails the inputs by exactly one bit cell.

Top module: `e1_tdm_mux`

## Requirements
- R1: While `rst_n` is low, `e1_out` is 0, and the signalling mode comes out of reset disabled.
- R2: In channels 1 to 15 and 17 to 31, the bit on `e1_out` is the bit that `dat_in` carried in the same bit position.
- R3: In timeslot 0, the bit on `e1_out` is the bit that `ctl_in` carried in the same bit position.
- R4: With the signalling mode disabled, timeslot 16 on `e1_out` is taken from `ctl_in`.
- R5: With the signalling mode enabled, timeslot 16 on `e1_out` is taken from `dat_in` without change.
- R6: The mode flag is bit 5 of channel 31 on `ctl_in`. Bits in a channel are numbered 7 down to 0 and sent most significant first, so bit 5 is the third bit cell of the channel, and 1 means enabled. The value captured there governs timeslot 16 from the next frame start onward. It never changes the frame in which it arrives.
- R7: A bit cell in which `fsync` is sampled high is taken as the first bit (bit 7) of channel 0. This holds at any count, so a pulse in the middle of a frame realigns the frame, and the frame start reloads the mode.
- R8: With no frame pulse, the position counter wraps from cell 255 to cell 0 and keeps the frame running.
- R9: A bit sampled on a falling edge appears on `e1_out` at the next rising edge, and `e1_out` changes only on rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, 2048 kHz; inputs sampled on falling edge, output launched on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame pulse; high during the first bit cell of a frame |
| dat_in | input | 1 | Serial data stream carrying the voice channels |
| ctl_in | input | 1 | Serial control stream carrying timeslots 0 and 16 and the mode flag |
| e1_out | output | 1 | Serial E1 line bitstream |

## Verification
The bench drives the control stream as the complement of the data stream in every cell except the mode flag, so any cell taken from the wrong source flips the output bit. It switches the mode on and off across frames to catch a flag that acts in its own frame or a frame late, or that is captured from the wrong bit cell. Two frames run with no frame pulse to expose a counter that stalls or wraps wrongly instead of running free. A frame pulse in the middle of a frame then checks that the counter realigns, rather than ignoring the pulse or waiting for the wrap. Each bit is also sampled after the falling edge, which exposes an output that moves on the wrong clock edge.

// File: rtl/e1_mux_pkg.sv
package e1_mux_pkg;

   // Source selector for a single line bit cell
   typedef enum logic {
      SRC_DATA = 1'b0,
      SRC_CTRL = 1'b1
   } src_e;

   // Per-timeslot source choice
   function automatic src_e pick_src(input logic is_sync_slot,
                                     input logic is_sig_slot,
                                     input logic ccs_on);
      if (is_sync_slot)
         return SRC_CTRL;
      if (is_sig_slot)
         return ccs_on ? SRC_DATA : SRC_CTRL;
      return SRC_DATA;
   endfunction

endpackage

// File: rtl/e1_slot_counter.sv
// Bit-cell position within the frame, advanced on the sampling (falling) edge.
module e1_slot_counter #(
   parameter int POS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_in,
   output logic [POS_W-1:0] cur_pos,
   output logic [POS_W-1:0] pos_q
);

   // Position of the cell being sampled at this falling edge
   always_comb begin
      if (sync_in)
         cur_pos = '0;
      else
         cur_pos = pos_q + POS_W'(1);
   end

   // Reset to the last cell so the first sample lands on cell 0
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         pos_q <= '1;
      else
         pos_q <= cur_pos;
   end

endmodule

// File: rtl/e1_mode_latch.sv
// Captures the signalling-mode flag from the control stream and arms it at frame start.
module e1_mode_latch #(
   parameter int CH_W      = 5,
   parameter int BIT_W     = 3,
   parameter int CH_BITS   = 8,
   parameter int MODE_SLOT = 31,
   parameter int MODE_BIT  = 5,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CH_W+BIT_W-1:0] cur_pos,
   input  logic                  ctl_in,
   output logic                  ccs_act
);

   localparam int POS_W = CH_W + BIT_W;

   logic [BIT_W-1:0] flag_ofs;
   logic             flag_hit;
   logic             frame_start;
   logic             ccs_pend;

   // Cell offset of the flag inside its channel depends on transmit bit order
   generate
      if (MSB_FIRST) begin : g_msb_first
         assign flag_ofs = BIT_W'(CH_BITS - 1 - MODE_BIT);
      end else begin : g_lsb_first
         assign flag_ofs = BIT_W'(MODE_BIT);
      end
   endgenerate

   assign flag_hit    = (cur_pos == {CH_W'(MODE_SLOT), flag_ofs});
   assign frame_start = (cur_pos == POS_W'(0));

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ccs_pend <= 1'b0;
         ccs_act  <= 1'b0;
      end else begin
         if (flag_hit)
            ccs_pend <= ctl_in;
         if (frame_start)
            ccs_act <= ccs_pend;
      end
   end

endmodule

// File: rtl/e1_slot_select.sv
// Chooses the source of each bit cell on the falling edge, launches it on the rising edge.
module e1_slot_select
   import e1_mux_pkg::*;
#(
   parameter int CH_W      = 5,
   parameter int SYNC_SLOT = 0,
   parameter int SIG_SLOT  = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CH_W-1:0] cur_chan,
   input  logic            ccs_act,
   input  logic            dat_in,
   input  logic            ctl_in,
   output logic            e1_out
);

   src_e src;
   logic pick_bit;
   logic sel_q;
   logic out_q;

   always_comb begin
      src      = pick_src(cur_chan == CH_W'(SYNC_SLOT),
                          cur_chan == CH_W'(SIG_SLOT),
                          ccs_act);
      pick_bit = (src == SRC_CTRL) ? ctl_in : dat_in;
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= 1'b0;
      else
         sel_q <= pick_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         out_q <= 1'b0;
      else
         out_q <= sel_q;
   end

   assign e1_out = out_q;

endmodule

// File: rtl/e1_tdm_mux.sv
module e1_tdm_mux #(
   parameter int CHANNELS  = 32,
   parameter int CH_BITS   = 8,
   parameter int SYNC_SLOT = 0,
   parameter int SIG_SLOT  = 16,
   parameter int MODE_SLOT = 31,
   parameter int MODE_BIT  = 5,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fsync,
   input  logic dat_in,
   input  logic ctl_in,
   output logic e1_out
);

   localparam int CH_W  = $clog2(CHANNELS);
   localparam int BIT_W = $clog2(CH_BITS);
   localparam int POS_W = CH_W + BIT_W;

   // Elaboration-time parameter checks
   generate
      if ((CHANNELS & (CHANNELS - 1)) != 0 || CHANNELS < 2) begin : g_bad_channels
         $error("CHANNELS must be a power of two");
      end
      if ((CH_BITS & (CH_BITS - 1)) != 0 || CH_BITS < 2) begin : g_bad_chbits
         $error("CH_BITS must be a power of two");
      end
      if (SYNC_SLOT >= CHANNELS || SIG_SLOT >= CHANNELS || MODE_SLOT >= CHANNELS) begin : g_bad_slot
         $error("slot index out of range");
      end
      if (SYNC_SLOT == SIG_SLOT) begin : g_bad_overlap
         $error("sync and signalling slots must differ");
      end
      if (MODE_BIT >= CH_BITS) begin : g_bad_modebit
         $error("MODE_BIT out of range");
      end
   endgenerate

   logic [POS_W-1:0] cur_pos;
   logic [POS_W-1:0] pos_q;
   logic             ccs_act;

   e1_slot_counter #(
      .POS_W (POS_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_in (fsync),
      .cur_pos (cur_pos),
      .pos_q   (pos_q)
   );

   e1_mode_latch #(
      .CH_W      (CH_W),
      .BIT_W     (BIT_W),
      .CH_BITS   (CH_BITS),
      .MODE_SLOT (MODE_SLOT),
      .MODE_BIT  (MODE_BIT),
      .MSB_FIRST (MSB_FIRST)
   ) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .cur_pos (cur_pos),
      .ctl_in  (ctl_in),
      .ccs_act (ccs_act)
   );

   e1_slot_select #(
      .CH_W      (CH_W),
      .SYNC_SLOT (SYNC_SLOT),
      .SIG_SLOT  (SIG_SLOT)
   ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur_chan (cur_pos[POS_W-1:BIT_W]),
      .ccs_act  (ccs_act),
      .dat_in   (dat_in),
      .ctl_in   (ctl_in),
      .e1_out   (e1_out)
   );

endmodule

// File: rtl/e1_tdm_mux_chk.sv
module e1_tdm_mux_chk #(
   parameter int CH_W      = 5,
   parameter int BIT_W     = 3,
   parameter int SYNC_SLOT = 0,
   parameter int SIG_SLOT  = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  fsync,
   input logic                  dat_in,
   input logic                  ctl_in,
   input logic                  e1_out,
   input logic [CH_W+BIT_W-1:0] pos_q,
   input logic                  ccs_act
);

   localparam int POS_W = CH_W + BIT_W;

   logic [CH_W-1:0] chan;
   assign chan = pos_q[POS_W-1:BIT_W];

   // R1: output held low in reset
   p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> (e1_out == 1'b0));

   // R2: voice timeslots follow the data stream
   p_voice_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (chan != CH_W'(SYNC_SLOT) && chan != CH_W'(SIG_SLOT)) |=> (e1_out == $past(dat_in)));

   // R3: timeslot 0 from control stream
   p_sync_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chan == CH_W'(SYNC_SLOT)) |=> (e1_out == $past(ctl_in)));

   // R4: timeslot 16 from control stream while mode off
   p_sig_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chan == CH_W'(SIG_SLOT) && !ccs_act) |=> (e1_out == $past(ctl_in)));

   // R5: timeslot 16 from data stream while mode on
   p_sig_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (chan == CH_W'(SIG_SLOT) && ccs_act) |=> (e1_out == $past(dat_in)));

   // R6: active mode changes only at a frame start
   p_mode_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_q != POS_W'(0)) |-> $stable(ccs_act));

   // R7: a sampled frame pulse places the cell at position 0
   p_fsync_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |-> (pos_q == POS_W'(0)));

   // R8: free-running advance and wrap without a pulse
   p_free_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !fsync |-> (pos_q == POS_W'($past(pos_q) + POS_W'(1))));

endmodule

bind e1_tdm_mux e1_tdm_mux_chk #(
   .CH_W      (CH_W),
   .BIT_W     (BIT_W),
   .SYNC_SLOT (SYNC_SLOT),
   .SIG_SLOT  (SIG_SLOT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .fsync   (fsync),
   .dat_in  (dat_in),
   .ctl_in  (ctl_in),
   .e1_out  (e1_out),
   .pos_q   (pos_q),
   .ccs_act (ccs_act)
);

// File: tb/tb_e1_tdm_mux.sv
module tb_e1_tdm_mux;

   localparam int NCELLS   = 7 * 256 + 120;
   localparam int RESYNC_N = 1636;

   logic clk    = 1'b0;
   logic rst_n  = 1'b0;
   logic fsync  = 1'b0;
   logic dat_in = 1'b0;
   logic ctl_in = 1'b0;
   logic e1_out;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;

   always #5 clk = ~clk;

   e1_tdm_mux dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .fsync  (fsync),
      .dat_in (dat_in),
      .ctl_in (ctl_in),
      .e1_out (e1_out)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: e1_out=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // Mode flag value sent in each frame index
   function automatic logic mode_for(input int f);
      return (f == 1 || f == 2 || f == 5) ? 1'b1 : 1'b0;
   endfunction

   initial begin : main
      int    pos;
      int    ch;
      int    b;
      int    f;
      logic  fs;
      logic  d;
      logic  c;
      logic  pend;
      logic  mact;
      logic  exp_prev;
      logic  seen;
      string tag_prev;
      bit    have;

      pos = 255; pend = 1'b0; mact = 1'b0; exp_prev = 1'b0; have = 1'b0; tag_prev = "";

      // R1: reset state
      for (int i = 0; i < 3; i++) begin
         @(posedge clk); #2;
         dat_in = i[0]; ctl_in = ~i[0];
         chk("R1", e1_out, 1'b0);
      end

      for (int n = 0; n < NCELLS; n++) begin
         @(posedge clk); #2;
         if (have) chk(tag_prev, e1_out, exp_prev);
         seen = e1_out;
         if (n == 0) rst_n = 1'b1;

         fs  = (n == 0 || n == 256 || n == 512 || n == 768 || n == RESYNC_N);
         pos = fs ? 0 : (pos + 1) % 256;
         ch  = pos / 8;
         b   = pos % 8;
         f   = n / 256;
         d   = 1'(((n * 29) ^ (n >> 5) ^ (n >> 9)) >> 2);
         c   = (ch == 31 && b == 2) ? mode_for(f) : ~d;

         fsync  = fs;
         dat_in = d;
         ctl_in = c;

         if (ch == 0)       exp_prev = c;
         else if (ch == 16) exp_prev = mact ? d : c;
         else               exp_prev = d;

         if (n >= RESYNC_N && n < RESYNC_N + 24)            tag_prev = "R7";
         else if (ch == 0)                                   tag_prev = "R3";
         else if (ch == 16 && (f == 1 || f == 2 || f == 4 || f == 5)) tag_prev = "R6";
         else if (ch == 16)                                  tag_prev = mact ? "R5" : "R4";
         else if (n >= 1024)                                 tag_prev = "R8";
         else                                                tag_prev = "R2";
         have = 1'b1;

         if (ch == 31 && b == 2) pend = c;
         if (pos == 0)           mact = pend;

         // R9: no change of the output across the falling edge
         @(negedge clk); #1;
         chk("R9", e1_out, seen);
      end

      @(posedge clk); #2;
      chk(tag_prev, e1_out, exp_prev);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : watchdog
      #(200000 * 10);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule